// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers sixteen level-sensitive interrupt lines for a single processor. Each line has a four-bit priority. It raises one registered request toward the processor whenever some asserted line carries a priority strictly greater than the current priority. The processor accepts the interrupt by reading the acknowledge register. That read returns the winning line's index, saves the old current priority on a hardware stack, raises the current priority to the winner's level and drops the request. A higher-priority line can therefore preempt a running handler, while equal or lower ones wait.

A handler finishes by writing any value to the end-of-interrupt register. The write pops the stack and restores the priority that was preempted. After the restore, no special attention goes to the interrupted source. Arbitration simply runs again against the restored level, so a line that software did not clear before the end-of-interrupt write is taken a second time. Software can also write the current priority directly without touching the stack. A status register shows the stack fill and two sticky flags for stack overflow and underflow.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_out is 0, the current priority is 0, the stack is empty, both status flags are 0 and every source priority reads 0.
- R2: The winner is the asserted source with the largest nonzero priority. On a tie the lowest source index wins. A source with priority 0 never wins.
- R3: irq_out is 1 exactly one clock after an asserted source's priority exceeds the current priority. A source whose priority is equal to or below the current priority never raises irq_out.
- R4: A read of address 0x01 (acknowledge) with an eligible winner returns bit 31 = 1 and the winner index in bits [3:0]. On that edge the old current priority is pushed, the current priority becomes the winner's priority, and irq_out is 0 in the following cycle. With no eligible winner, the read returns 0 and changes nothing.
- R5: A write of any data to address 0x02 (end of interrupt) pops the stack and loads the popped value into the current priority.
- R6: After a pop, a source that is still asserted with a priority above the restored level raises irq_out again. Sources at or below that level do not.
- R7: A pop on an empty stack sets the current priority to 0 and sets the underflow flag.
- R8: The stack holds 15 entries. A push when it is full overwrites the top entry, leaves the depth at 15 and sets the overflow flag.
- R9: A write to address 0x00 sets the current priority from data bits [3:0]. The stack depth is unchanged. Reading 0x00 returns the current priority in bits [3:0].
- R10: Addresses 0x10 + n hold source n's priority in bits [3:0], readable and writable.
- R11: Address 0x03 reads the overflow flag in bit 0, the underflow flag in bit 1 and the stack depth in bits [11:8]. Writing 1 to bit 0 or bit 1 clears that flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_src | input | 16 | Level interrupt lines, one per source |
| reg_wr | input | 1 | Register write strobe; takes precedence over reg_rd |
| reg_rd | input | 1 | Register read strobe; acknowledge side effects at the edge |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address and state |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The arbiter is exercised with a single line, with several lines at distinct priorities, with ties at one priority, and with lines set to priority 0. These cases separate a wrong comparison direction from a wrong tie rule and from a missing zero exclusion. Nested acknowledges with increasing priorities, followed by end-of-interrupt writes, show whether the stack restores levels in last-in order. Leaving a source asserted across the pop shows that servicing repeats. Sixteen acknowledges at one priority, and pops past the bottom of the stack, expose the overwrite and underflow paths. A long seeded random mix of line changes, priority writes, acknowledges, pops and direct writes is compared against a bench model after every step.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CURPRI = 5'h00;
  localparam logic [ADDR_W-1:0] A_ACK    = 5'h01;
  localparam logic [ADDR_W-1:0] A_EOI    = 5'h02;
  localparam logic [ADDR_W-1:0] A_STAT   = 5'h03;

  localparam int ST_OVF_BIT   = 0;
  localparam int ST_UNF_BIT   = 1;
  localparam int ST_DEPTH_LSB = 8;
  localparam int ACK_VLD_BIT  = 31;
endpackage

// File: rtl/prio_rst_sync.sv
module prio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_n = out_q;
endmodule

// File: rtl/prio_cfg.sv
module prio_cfg #(
  parameter int NSRC = 16,
  parameter int PW   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0]           wen,
  input  logic [PW-1:0]             wdata,
  output logic [NSRC-1:0][PW-1:0]   prio
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic [PW-1:0] prio_q;
    logic [PW-1:0] prio_d;

    always_comb begin
      prio_d = prio_q;
      if (wen[g]) prio_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prio_q <= '0;
      else if (wen[g]) prio_q <= prio_d;
    end

    assign prio[g] = prio_q;
  end
endmodule

// File: rtl/prio_arb.sv
module prio_arb #(
  parameter int NSRC = 16,
  parameter int PW   = 4,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]          req,
  input  logic [NSRC-1:0][PW-1:0]  prio,
  input  logic [PW-1:0]            cur,
  output logic [IDXW-1:0]          win_idx,
  output logic [PW-1:0]            win_prio,
  output logic                     win_hit
);
  logic [PW-1:0]   best_p;
  logic [IDXW-1:0] best_i;

  // Ascending scan with strict compare: lowest index keeps a tie,
  // and a zero priority can never displace the initial zero.
  always_comb begin
    best_p = '0;
    best_i = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (prio[i] > best_p)) begin
        best_p = prio[i];
        best_i = IDXW'(i);
      end
    end
  end

  assign win_idx  = best_i;
  assign win_prio = best_p;
  assign win_hit  = best_p > cur;
endmodule

// File: rtl/prio_lifo.sv
module prio_lifo #(
  parameter int DEPTH = 15,
  parameter int PW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] din,
  output logic [PW-1:0] top,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [CW-1:0]   cnt_q;
  logic [CW-1:0]   cnt_d;
  logic [PW-1:0]   mem [DEPTH];
  logic [DEPTH-1:0] wen;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (push && !full)      cnt_d = cnt_q + CW'(1);
    else if (pop && !empty) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (push || pop) cnt_q <= cnt_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign wen[g] = push && (full ? (g == DEPTH - 1) : (cnt_q == CW'(g)));

    always_ff @(posedge clk) begin
      if (wen[g]) mem[g] <= din;
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CW'(i + 1)) top = mem[i];
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NSRC  = 16,
  parameter int PW    = 4,
  parameter int DEPTH = 15,
  parameter int DW    = 32,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSRC-1:0]     irq_src,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DW-1:0]       reg_wdata,
  output logic [DW-1:0]       reg_rdata,
  output logic                irq_out
);
  logic rst_int_n;

  prio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  // ---------------- decode ----------------
  logic                 wr_cur, wr_eoi, wr_stat, ack_rd, ack_fire;
  logic [NSRC-1:0]      prio_wen;
  logic [ADDR_W-2:0]    prio_sel;

  assign wr_cur  = reg_wr && (reg_addr == A_CURPRI);
  assign wr_eoi  = reg_wr && (reg_addr == A_EOI);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign ack_rd  = reg_rd && !reg_wr && (reg_addr == A_ACK);
  assign prio_sel = reg_addr[ADDR_W-2:0];

  for (genvar g = 0; g < NSRC; g++) begin : g_wen
    assign prio_wen[g] = reg_wr && reg_addr[ADDR_W-1] &&
                         (prio_sel == (ADDR_W-1)'(g));
  end

  // ---------------- datapath ----------------
  logic [NSRC-1:0][PW-1:0] prio;
  logic [IDXW-1:0]         win_idx;
  logic [PW-1:0]           win_prio;
  logic                    win_hit;
  logic [PW-1:0]           cur_q, cur_d;
  logic [PW-1:0]           lifo_top;
  logic [CW-1:0]           lifo_cnt;
  logic                    lifo_full, lifo_empty;
  logic                    ovf_q, ovf_d, unf_q, unf_d;
  logic                    irq_q, irq_d;
  logic                    state_en;

  prio_cfg #(.NSRC(NSRC), .PW(PW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wen   (prio_wen),
    .wdata (reg_wdata[PW-1:0]),
    .prio  (prio)
  );

  prio_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
    .req      (irq_src),
    .prio     (prio),
    .cur      (cur_q),
    .win_idx  (win_idx),
    .win_prio (win_prio),
    .win_hit  (win_hit)
  );

  assign ack_fire = ack_rd && win_hit;

  prio_lifo #(.DEPTH(DEPTH), .PW(PW)) u_lifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (ack_fire),
    .pop   (wr_eoi),
    .din   (cur_q),
    .top   (lifo_top),
    .cnt   (lifo_cnt),
    .full  (lifo_full),
    .empty (lifo_empty)
  );

  // ---------------- next state ----------------
  always_comb begin
    cur_d = cur_q;
    ovf_d = ovf_q;
    unf_d = unf_q;
    if (ack_fire) begin
      cur_d = win_prio;
      if (lifo_full) ovf_d = 1'b1;
    end else if (wr_eoi) begin
      cur_d = lifo_empty ? '0 : lifo_top;
      if (lifo_empty) unf_d = 1'b1;
    end else if (wr_cur) begin
      cur_d = reg_wdata[PW-1:0];
    end else if (wr_stat) begin
      if (reg_wdata[ST_OVF_BIT]) ovf_d = 1'b0;
      if (reg_wdata[ST_UNF_BIT]) unf_d = 1'b0;
    end
  end

  assign irq_d    = win_hit && !ack_fire;
  assign state_en = ack_fire || wr_eoi || wr_cur || wr_stat;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      cur_q <= '0;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else if (state_en) begin
      cur_q <= cur_d;
      ovf_q <= ovf_d;
      unf_q <= unf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq_out = irq_q;

  // ---------------- read mux ----------------
  always_comb begin
    reg_rdata = '0;
    if (reg_addr[ADDR_W-1]) begin
      if (int'(prio_sel) < NSRC) reg_rdata[PW-1:0] = prio[prio_sel[IDXW-1:0]];
    end else begin
      case (reg_addr)
        A_CURPRI: reg_rdata[PW-1:0] = cur_q;
        A_ACK: begin
          if (win_hit) begin
            reg_rdata[ACK_VLD_BIT] = 1'b1;
            reg_rdata[IDXW-1:0]    = win_idx;
          end
        end
        A_STAT: begin
          reg_rdata[ST_OVF_BIT]          = ovf_q;
          reg_rdata[ST_UNF_BIT]          = unf_q;
          reg_rdata[ST_DEPTH_LSB +: CW]  = lifo_cnt;
        end
        default: reg_rdata = '0;
      endcase
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[DW-1:PW];
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int PW = 4,
  parameter int CW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              irq_out,
  input logic              win_hit,
  input logic [PW-1:0]     win_prio,
  input logic [PW-1:0]     cur_q,
  input logic [PW-1:0]     lifo_top,
  input logic [CW-1:0]     lifo_cnt,
  input logic              lifo_full,
  input logic              lifo_empty,
  input logic              ovf_q,
  input logic              unf_q
);
  logic ack_c, eoi_c, cur_c;
  assign ack_c = reg_rd && !reg_wr && (reg_addr == A_ACK) && win_hit;
  assign eoi_c = reg_wr && (reg_addr == A_EOI);
  assign cur_c = reg_wr && (reg_addr == A_CURPRI);

  a_r3_irq_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(win_hit));

  a_r3_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && !ack_c) |=> irq_out);

  a_r4_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ack_c |=> !irq_out);

  a_r4_ack_raises_level: assert property (@(posedge clk) disable iff (!rst_n)
    ack_c |=> (cur_q == $past(win_prio)));

  a_r5_eoi_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_c && !lifo_empty) |=> (cur_q == $past(lifo_top)));

  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_c && lifo_empty) |=> (cur_q == '0) && unf_q);

  a_r8_full_push: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_c && lifo_full) |=> lifo_full && ovf_q);

  a_r9_cur_write_keeps_depth: assert property (@(posedge clk) disable iff (!rst_n)
    cur_c |=> (lifo_cnt == $past(lifo_cnt)));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .irq_out    (irq_out),
  .win_hit    (win_hit),
  .win_prio   (win_prio),
  .cur_q      (cur_q),
  .lifo_top   (lifo_top),
  .lifo_cnt   (lifo_cnt),
  .lifo_full  (lifo_full),
  .lifo_empty (lifo_empty),
  .ovf_q      (ovf_q),
  .unf_q      (unf_q)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk;
  logic        rst_n;
  logic [15:0] irq_src;
  logic        reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_out;

  int n_chk, n_fail;
  bit done;

  // bench model
  int m_prio [16];
  int m_cur;
  int m_stk [15];
  int m_dep;
  bit m_ovf, m_unf;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic void m_arb(output int idx, output int p);
    idx = 0; p = 0;
    for (int i = 0; i < 16; i++)
      if (irq_src[i] && m_prio[i] > p) begin p = m_prio[i]; idx = i; end
  endfunction

  function automatic bit m_elig();
    int i, p;
    m_arb(i, p);
    return p > m_cur;
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic bus_write(logic [4:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
    if (a == 5'h00) m_cur = int'(d[3:0]);
    else if (a == 5'h02) begin
      if (m_dep == 0) begin m_cur = 0; m_unf = 1'b1; end
      else begin m_dep--; m_cur = m_stk[m_dep]; end
    end else if (a == 5'h03) begin
      if (d[0]) m_ovf = 1'b0;
      if (d[1]) m_unf = 1'b0;
    end else if (a[4]) m_prio[a[3:0]] = int'(d[3:0]);
  endtask

  task automatic bus_read(logic [4:0] a, output logic [31:0] d);
    int wi, wp;
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    m_arb(wi, wp);
    tick();
    reg_rd = 1'b0;
    if (a == 5'h01 && wp > m_cur) begin
      if (m_dep == 15) begin m_stk[14] = m_cur; m_ovf = 1'b1; end
      else begin m_stk[m_dep] = m_cur; m_dep++; end
      m_cur = wp;
    end
  endtask

  function automatic logic [31:0] exp_ack();
    int wi, wp;
    m_arb(wi, wp);
    return (wp > m_cur) ? (32'h8000_0000 | 32'(wi)) : 32'h0;
  endfunction

  function automatic logic [31:0] exp_stat();
    return {20'h0, 4'(m_dep), 6'h0, m_unf, m_ovf};
  endfunction

  task automatic do_ack(string req);
    logic [31:0] d, e;
    e = exp_ack();
    bus_read(5'h01, d);
    check(req, d, e);
  endtask

  task automatic chk_irq(string req);
    tick();
    check(req, 32'(irq_out), 32'(m_elig()));
  endtask

  task automatic chk_state(string req);
    logic [31:0] d;
    bus_read(5'h00, d); check(req, d, 32'(m_cur));
    bus_read(5'h03, d); check(req, d, exp_stat());
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    n_chk = 0; n_fail = 0;
    irq_src = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
    for (int i = 0; i < 16; i++) m_prio[i] = 0;
    m_cur = 0; m_dep = 0; m_ovf = 0; m_unf = 0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    check("R1 irq", 32'(irq_out), 32'h0);
    chk_state("R1 cur/stat");
    for (int i = 0; i < 16; i++) begin
      bus_read(5'h10 + 5'(i), d); check("R1 prio", d, 32'h0);
    end

    // R10 priority registers
    for (int i = 0; i < 16; i++) bus_write(5'h10 + 5'(i), 32'(i));
    for (int i = 0; i < 16; i++) begin
      bus_read(5'h10 + 5'(i), d); check("R10 prio rd", d, 32'(i));
    end

    // R2 priority 0 never interrupts
    irq_src = 16'h0001; chk_irq("R2 prio0");
    check("R2 prio0 low", 32'(irq_out), 32'h0);
    // R2 tie: sources 3 and 5 both at priority 7, lowest index
    bus_write(5'h13, 32'd7); bus_write(5'h15, 32'd7);
    irq_src = 16'h0028; chk_irq("R2 tie irq");
    do_ack("R2 tie index");
    bus_write(5'h02, 0);
    // R2 highest wins
    irq_src = 16'h0A28; chk_irq("R2 max irq");
    do_ack("R2 max index");
    bus_write(5'h02, 0);
    irq_src = '0;

    // R3 latency and strictness
    bus_write(5'h00, 32'd6); tick();
    check("R3 idle", 32'(irq_out), 32'h0);
    irq_src = 16'h0040; #1;
    check("R3 equal prio blocked", 32'(irq_out), 32'h0);
    tick(); check("R3 equal prio blocked", 32'(irq_out), 32'h0);
    irq_src = 16'h0080; #1;
    check("R3 before edge", 32'(irq_out), 32'h0);
    tick(); check("R3 one cycle", 32'(irq_out), 32'h1);

    // R4 ack drops irq, raises level
    do_ack("R4 ack vec");
    #1 check("R4 irq dropped", 32'(irq_out), 32'h0);
    chk_state("R4 pushed");
    do_ack("R4 no eligible");
    chk_state("R4 unchanged");
    // R6 nested preemption, then pops with source still asserted
    irq_src = 16'h0280; chk_irq("R6 preempt irq");
    do_ack("R6 nested ack");
    chk_state("R6 depth2");
    irq_src = 16'h0080;
    bus_write(5'h02, 0); chk_irq("R5 pop level7 no irq");
    chk_state("R5 restored 7");
    bus_write(5'h02, 0); chk_irq("R6 refire after pop");
    check("R6 refire high", 32'(irq_out), 32'h1);
    irq_src = '0; chk_irq("R6 cleared");

    // R7 empty pop
    bus_write(5'h02, 0);
    chk_state("R7 underflow");
    bus_write(5'h03, 32'h2);
    chk_state("R11 clear unf");

    // R8 overflow by 16 pushes at priority 1
    bus_write(5'h10, 32'd1); irq_src = 16'h0001;
    for (int k = 0; k < 16; k++) begin
      bus_write(5'h00, 0);
      do_ack("R8 ack");
    end
    chk_state("R8 full overwrite");
    // R9 direct write leaves depth
    bus_write(5'h00, 32'd9);
    chk_state("R9 direct");
    bus_write(5'h02, 0); chk_state("R8 top overwritten");
    bus_write(5'h03, 32'h3); chk_state("R11 clear ovf");
    for (int k = 0; k < 15; k++) bus_write(5'h02, 0);
    bus_write(5'h03, 32'h3); irq_src = '0;
    chk_state("R11 drained");

    // random mix
    for (int it = 0; it < 1500; it++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1: irq_src = 16'($urandom);
        2: bus_write(5'h10 + 5'($urandom_range(0, 15)), 32'($urandom_range(0, 15)));
        3, 4, 5: do_ack("R4 rand ack");
        6, 7: bus_write(5'h02, $urandom);
        8: bus_write(5'h00, 32'($urandom_range(0, 15)));
        default: chk_state("R11 rand state");
      endcase
      chk_irq("R3 rand irq");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule